// File: doc/BRIEF.md
# Serial Access Buffer with Start Pointer

This block is the serial side of a dual-ported frame memory. It is a static buffer of 512 four-bit entries, split into a lower and an upper half of 256 entries each, with its own address pointer. A single-cycle load copies a complete 512x4 row image into the buffer. A single-cycle dump copies the buffer out into a row image. Both commands set the pointer to a 9-bit start address taken from the column address.

After a transfer, each serial tick moves the pointer forward by one entry. In read mode the entry at the pointer is driven on the serial output. In write mode the serial input is stored at the pointer before the pointer moves. A status output reports which half of the buffer the pointer is in, so a host can refill one half while the other is being streamed. While the serial enable is low, the serial output driver is off and ticks have no effect. The storage needs no refresh.

The serial tick is a one-cycle pulse in the `clk` domain. Row entry `i` sits in bits `[4i+3:4i]` of the row vectors.

Top module: `sam_port`

## Requirements
- R1: After reset the pointer is 0, `half_hi` is 0, `sdq_oe` is 0, `sdq_out` is 0, `row_out` is all zeros and every buffer entry is 0.
- R2: A cycle with `xfer_rd` high copies `row_in` (entry i in bits [4i+3:4i]) into the buffer and sets the pointer to `start_addr`, both visible from the next cycle.
- R3: A cycle with `xfer_wr` high (and `xfer_rd` low) copies the buffer into `row_out` (entry i in bits [4i+3:4i]) and sets the pointer to `start_addr`, both visible from the next cycle; `row_out` otherwise holds.
- R4: With `ser_en` high and `ser_wr` low, `sdq_out` shows the entry at the pointer, and each cycle with `ser_tick` high advances the pointer by one.
- R5: With `ser_en` high and `ser_wr` high, a cycle with `ser_tick` high stores `sdq_in` at the current pointer and then advances the pointer by one.
- R6: The pointer wraps from 511 to 0.
- R7: `half_hi` is 0 while the pointer is in 0..255 and 1 while it is in 256..511.
- R8: While `ser_en` is low, `sdq_oe` is 0, `sdq_out` is 0, and ticks neither move the pointer nor write the buffer.
- R9: A transfer in the same cycle as a tick takes precedence and the tick is dropped; if `xfer_rd` and `xfer_wr` are both high, only the load takes place.
- R10: `sdq_oe` is 1 exactly when `ser_en` is high and `ser_wr` is low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| xfer_rd | input | 1 | Load row image into buffer, set pointer |
| xfer_wr | input | 1 | Dump buffer into row image, set pointer |
| start_addr | input | 9 | Pointer start value for transfers |
| row_in | input | 2048 | Row image to load |
| row_out | output | 2048 | Row image captured by the last dump |
| ser_en | input | 1 | Serial port enable |
| ser_wr | input | 1 | Serial direction, 1 = write into buffer |
| ser_tick | input | 1 | Serial clock step, one-cycle pulse |
| sdq_in | input | 4 | Serial write data |
| sdq_out | output | 4 | Serial read data, 0 when not driven |
| sdq_oe | output | 1 | Serial output driver enable |
| half_hi | output | 1 | Pointer is in the upper half |

## Verification
The bench builds the block with its default depth of 512 and width of 4. At these values the upper-half boundary at 256 and the wrap from 511 to 0 can both be reached from transfer start addresses within a few ticks. Whole-row load and dump are checked entry by entry against a behavioural model. Write-then-dump sequences check that serial writes land at the correct entries, and that writes with the enable low are lost.

// File: rtl/sam_pkg.sv
package sam_pkg;

    typedef enum logic [2:0] {
        OP_IDLE,
        OP_LOAD,
        OP_DUMP,
        OP_SHIFT_RD,
        OP_SHIFT_WR
    } sam_op_e;

    function automatic sam_op_e decode_op(input logic rd, input logic wr,
                                          input logic en, input logic tick,
                                          input logic dir_wr);
        if (rd)               return OP_LOAD;
        else if (wr)          return OP_DUMP;
        else if (en && tick)  return dir_wr ? OP_SHIFT_WR : OP_SHIFT_RD;
        else                  return OP_IDLE;
    endfunction

endpackage

// File: rtl/sam_ptr.sv
module sam_ptr #(
    parameter int DEPTH = 512,
    localparam int AW = $clog2(DEPTH)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          load,
    input  logic [AW-1:0] load_val,
    input  logic          step,
    output logic [AW-1:0] ptr
);

    typedef struct packed {
        logic [AW-1:0] ptr;
    } ptr_state_t;

    ptr_state_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (load) begin
            st_d.ptr = load_val;
        end else if (step) begin
            if (st_q.ptr == AW'(DEPTH - 1)) st_d.ptr = '0;
            else                            st_d.ptr = st_q.ptr + AW'(1);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign ptr = st_q.ptr;

endmodule

// File: rtl/sam_store.sv
module sam_store #(
    parameter int DEPTH = 512,
    parameter int WIDTH = 4,
    localparam int AW = $clog2(DEPTH),
    localparam int RW = DEPTH * WIDTH
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load_row,
    input  logic [RW-1:0]    row_in,
    input  logic             dump_row,
    input  logic             wr_en,
    input  logic [AW-1:0]    addr,
    input  logic [WIDTH-1:0] wr_data,
    output logic [WIDTH-1:0] rd_data,
    output logic [RW-1:0]    row_out
);

    typedef struct {
        logic [WIDTH-1:0] mem [DEPTH];
        logic [RW-1:0]    row;
    } store_state_t;

    store_state_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (load_row) begin
            for (int i = 0; i < DEPTH; i++) begin
                st_d.mem[i] = row_in[i*WIDTH +: WIDTH];
            end
        end else if (wr_en) begin
            st_d.mem[addr] = wr_data;
        end
        if (dump_row) begin
            for (int i = 0; i < DEPTH; i++) begin
                st_d.row[i*WIDTH +: WIDTH] = st_q.mem[i];
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < DEPTH; i++) begin
                st_q.mem[i] <= '0;
            end
            st_q.row <= '0;
        end else begin
            st_q.mem <= st_d.mem;
            st_q.row <= st_d.row;
        end
    end

    assign rd_data = st_q.mem[addr];
    assign row_out = st_q.row;

endmodule

// File: rtl/sam_port.sv
module sam_port #(
    parameter int DEPTH = 512,
    parameter int WIDTH = 4,
    localparam int AW = $clog2(DEPTH),
    localparam int RW = DEPTH * WIDTH
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             xfer_rd,
    input  logic             xfer_wr,
    input  logic [AW-1:0]    start_addr,
    input  logic [RW-1:0]    row_in,
    output logic [RW-1:0]    row_out,
    input  logic             ser_en,
    input  logic             ser_wr,
    input  logic             ser_tick,
    input  logic [WIDTH-1:0] sdq_in,
    output logic [WIDTH-1:0] sdq_out,
    output logic             sdq_oe,
    output logic             half_hi
);
    import sam_pkg::*;

    sam_op_e          op;
    logic [AW-1:0]    ptr;
    logic [WIDTH-1:0] rd_data;
    logic             set_ptr;
    logic             step_ptr;

    always_comb begin
        op       = decode_op(xfer_rd, xfer_wr, ser_en, ser_tick, ser_wr);
        set_ptr  = (op == OP_LOAD) || (op == OP_DUMP);
        step_ptr = (op == OP_SHIFT_RD) || (op == OP_SHIFT_WR);
    end

    sam_ptr #(.DEPTH(DEPTH)) u_ptr (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (set_ptr),
        .load_val (start_addr),
        .step     (step_ptr),
        .ptr      (ptr)
    );

    sam_store #(.DEPTH(DEPTH), .WIDTH(WIDTH)) u_store (
        .clk      (clk),
        .rst_n    (rst_n),
        .load_row (op == OP_LOAD),
        .row_in   (row_in),
        .dump_row (op == OP_DUMP),
        .wr_en    (op == OP_SHIFT_WR),
        .addr     (ptr),
        .wr_data  (sdq_in),
        .rd_data  (rd_data),
        .row_out  (row_out)
    );

    always_comb begin
        sdq_oe  = ser_en && !ser_wr;
        sdq_out = sdq_oe ? rd_data : '0;
        half_hi = (ptr >= AW'(DEPTH / 2));
    end

endmodule

// File: rtl/sam_port_chk.sv
module sam_port_chk #(
    parameter int DEPTH = 512,
    parameter int WIDTH = 4,
    localparam int AW = $clog2(DEPTH)
) (
    input logic             clk,
    input logic             rst_n,
    input logic             xfer_rd,
    input logic             xfer_wr,
    input logic             ser_en,
    input logic             ser_wr,
    input logic             ser_tick,
    input logic [AW-1:0]    start_addr,
    input logic [AW-1:0]    ptr,
    input logic             sdq_oe,
    input logic [WIDTH-1:0] sdq_out,
    input logic             half_hi
);

    // R2
    load_sets_ptr_chk: assert property (@(posedge clk) disable iff (!rst_n)
        xfer_rd |=> ptr == $past(start_addr));

    // R3
    dump_sets_ptr_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (xfer_wr && !xfer_rd) |=> ptr == $past(start_addr));

    // R6
    ptr_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!xfer_rd && !xfer_wr && ser_en && ser_tick)
        |=> ptr == (($past(ptr) == AW'(DEPTH - 1)) ? '0 : $past(ptr) + AW'(1)));

    // R8
    idle_ptr_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!xfer_rd && !xfer_wr && !ser_en) |=> $stable(ptr));

    // R8
    off_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !ser_en |-> (!sdq_oe && sdq_out == '0));

    // R7
    half_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
        half_hi == (ptr >= AW'(DEPTH / 2)));

endmodule

bind sam_port sam_port_chk #(.DEPTH(DEPTH), .WIDTH(WIDTH)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .xfer_rd    (xfer_rd),
    .xfer_wr    (xfer_wr),
    .ser_en     (ser_en),
    .ser_wr     (ser_wr),
    .ser_tick   (ser_tick),
    .start_addr (start_addr),
    .ptr        (ptr),
    .sdq_oe     (sdq_oe),
    .sdq_out    (sdq_out),
    .half_hi    (half_hi)
);

// File: tb/sam_port_bench.sv
`timescale 1ns/1ps
module sam_port_bench;
    localparam int D  = 512;
    localparam int W  = 4;
    localparam int RW = D * W;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          xfer_rd = 1'b0, xfer_wr = 1'b0;
    logic [8:0]    start_addr = '0;
    logic [RW-1:0] row_in = '0;
    logic [RW-1:0] row_out;
    logic          ser_en = 1'b0, ser_wr = 1'b0, ser_tick = 1'b0;
    logic [W-1:0]  sdq_in = '0;
    logic [W-1:0]  sdq_out;
    logic          sdq_oe, half_hi;

    int checks = 0;
    int errors = 0;
    string phase = "R1";
    bit done = 1'b0;

    int m_mem [D];
    int m_row [D];
    int m_ptr = 0;

    always #10 clk = ~clk;

    sam_port u_sam_port (
        .clk(clk), .rst_n(rst_n), .xfer_rd(xfer_rd), .xfer_wr(xfer_wr),
        .start_addr(start_addr), .row_in(row_in), .row_out(row_out),
        .ser_en(ser_en), .ser_wr(ser_wr), .ser_tick(ser_tick),
        .sdq_in(sdq_in), .sdq_out(sdq_out), .sdq_oe(sdq_oe), .half_hi(half_hi)
    );

    initial begin
        for (int i = 0; i < D; i++) begin
            m_mem[i] = 0;
            m_row[i] = 0;
        end
    end

    // reference model
    always @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            m_ptr = 0;
            for (int i = 0; i < D; i++) begin
                m_mem[i] = 0;
                m_row[i] = 0;
            end
        end else if (xfer_rd) begin
            for (int i = 0; i < D; i++) m_mem[i] = int'(row_in[i*W +: W]);
            m_ptr = int'(start_addr);
        end else if (xfer_wr) begin
            for (int i = 0; i < D; i++) m_row[i] = m_mem[i];
            m_ptr = int'(start_addr);
        end else if (ser_en && ser_tick) begin
            if (ser_wr) m_mem[m_ptr] = int'(sdq_in);
            m_ptr = (m_ptr + 1) % D;
        end
    end

    task automatic check(input string req, input string what, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    // compare on every clock, away from the active edge
    always @(negedge clk) begin
        if (!done) begin
            int exp_oe, exp_out, row_bad;
            exp_oe  = (ser_en && !ser_wr) ? 1 : 0;
            exp_out = exp_oe ? m_mem[m_ptr] : 0;
            check({phase, "/R10"}, "sdq_oe", int'(sdq_oe), exp_oe);
            check({phase, "/R4"}, "sdq_out", int'(sdq_out), exp_out);
            check({phase, "/R7"}, "half_hi", int'(half_hi), (m_ptr >= D/2) ? 1 : 0);
            row_bad = -1;
            for (int i = 0; i < D; i++)
                if (int'(row_out[i*W +: W]) != m_row[i] && row_bad < 0) row_bad = i;
            check({phase, "/R3"}, "row_out first mismatching entry", row_bad, -1);
        end
    end

    task automatic cyc(input int n = 1);
        for (int k = 0; k < n; k++) begin
            @(posedge clk);
            #3;
            xfer_rd = 1'b0; xfer_wr = 1'b0; ser_tick = 1'b0;
        end
    endtask

    task automatic fill_row(input int seed);
        for (int i = 0; i < D; i++) row_in[i*W +: W] = W'((i * seed + (i >> 3) + seed) & 15);
    endtask

    task automatic load(input int addr);
        @(posedge clk); #3;
        start_addr = 9'(addr); xfer_rd = 1'b1;
        cyc();
    endtask

    task automatic ticks(input int n);
        for (int k = 0; k < n; k++) begin
            @(posedge clk); #3;
            ser_tick = 1'b1; sdq_in = W'($urandom_range(0, 15));
            cyc();
        end
    endtask

    initial begin
        #4_000_000;
        if (!done) begin
            done = 1'b1;
            checks++; errors++;
            $display("FAIL watchdog: actual=hung expected=finished");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        // R1 reset state
        phase = "R1";
        repeat (3) @(posedge clk);
        #3 rst_n = 1'b1;
        ser_en = 1'b1;
        cyc(2);
        check("R1", "sdq_out after reset", int'(sdq_out), 0);
        check("R1", "half_hi after reset", int'(half_hi), 0);

        // R2 load then stream read across the half boundary (R7)
        phase = "R2";
        fill_row(3);
        load(250);
        check("R2", "first entry after load", int'(sdq_out), int'(row_in[250*W +: W]));
        phase = "R7";
        ticks(10);
        check("R7", "half_hi past 255", int'(half_hi), 1);

        // R8 enable low: ticks ignored
        phase = "R8";
        ser_en = 1'b0;
        ticks(5);
        check("R8", "sdq_oe while disabled", int'(sdq_oe), 0);
        ser_en = 1'b1;
        cyc();
        check("R8", "pointer held (entry 260)", int'(sdq_out), int'(row_in[260*W +: W]));

        // R6 wrap
        phase = "R6";
        fill_row(7);
        load(509);
        ticks(4);
        check("R6", "entry after wrap (1)", int'(sdq_out), int'(row_in[1*W +: W]));
        check("R6", "half_hi after wrap", int'(half_hi), 0);

        // R5 serial writes, then dump (R3)
        phase = "R5";
        ser_wr = 1'b1;
        fill_row(5);
        load(300);
        ticks(40);
        ser_en = 1'b0;
        ticks(3);
        ser_en = 1'b1;
        phase = "R3";
        @(posedge clk); #3; start_addr = 9'd300; xfer_wr = 1'b1; cyc();
        ser_wr = 1'b0;
        cyc();
        ticks(45);

        // R9 precedence
        phase = "R9";
        fill_row(11);
        @(posedge clk); #3;
        start_addr = 9'd100; xfer_rd = 1'b1; ser_tick = 1'b1;
        cyc();
        check("R9", "tick dropped on load", int'(sdq_out), int'(row_in[100*W +: W]));
        @(posedge clk); #3;
        start_addr = 9'd400; xfer_rd = 1'b1; xfer_wr = 1'b1; row_in = '0;
        cyc();
        check("R9", "load wins over dump", int'(sdq_out), 0);
        ser_wr = 1'b1;
        ticks(2);
        ser_wr = 1'b0;
        @(posedge clk); #3; start_addr = 9'd0; xfer_wr = 1'b1; ser_tick = 1'b1; cyc();
        check("R9", "tick dropped on dump", int'(half_hi), 0);
        cyc(3);

        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule